// File: doc/BRIEF.md
# DTMF Tone-Pair Frequency Detector

This block takes two full-swing square waves from an analog front end. One carries the low-group (row) tone and one carries the high-group (column) tone. Each wave passes through a two-stage synchronizer. The block then counts reference-clock cycles between consecutive rising edges. It keeps a running sum of the last four periods and compares that sum against an acceptance window placed around each of the four standard frequencies of its group.

When both channels sit inside a window, the early-steering output rises. In the same cycle, the 4-bit digit code of the row/column pair is loaded. A channel stops counting as valid in two cases: its averaged period leaves every window, or its wave shows no rising edge for longer than 4 ms of reference clock. The code register holds its value while early steering is low, so a downstream guard-time stage can sample it later.

The reference clock rate is a parameter, with a default of 3.579545 MHz. The averaging depth and the tolerance divider are also parameters.

Top module: `dtmf_pair_detector`

## Requirements
- R1: While reset is asserted and right after it is released, `early_steer` is 0 and `digit_code` is 4'b0000.
- R2: On the low channel, a period near 697, 770, 852 or 941 Hz selects row 0, 1, 2 or 3 respectively.
- R3: On the high channel, a period near 1209, 1336, 1477 or 1633 Hz selects column 0, 1, 2 or 3 respectively.
- R4: The code loaded for each (row, column) pair is as follows.
  - Row 0 with columns 0..3 gives 1, 2, 3, 13.
  - Row 1 with columns 0..3 gives 4, 5, 6, 14.
  - Row 2 with columns 0..3 gives 7, 8, 9, 15.
  - Row 3 with columns 0..3 gives 11, 10, 12, 0.
- R5: A channel counts as valid only after four complete periods have been measured, which takes five rising edges. `early_steer` never rises before both channels have seen five rising edges.
- R6: A channel is valid only when the sum of its last four periods lies within ±1/40 of the nominal four-period count of some frequency in its group. A tone 7% off nominal is rejected, and so is a tone between groups. A tone 2% off nominal is accepted.
- R7: If either channel has no rising edge for more than CLK_HZ/250 cycles (4 ms), `early_steer` falls within a few cycles, even while the other channel keeps running.
- R8: A single out-of-window period on a running channel drops `early_steer`. It rises again once four good periods follow.
- R9: While `early_steer` is low, `digit_code` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (CLK_HZ) |
| rst_n | input | 1 | Asynchronous reset, active low |
| lo_wave | input | 1 | Limited low-group (row) square wave |
| hi_wave | input | 1 | Limited high-group (column) square wave |
| early_steer | output | 1 | High while both channels hold a valid tone |
| digit_code | output | 4 | Code of the last valid tone pair |

## Verification
A rising input edge reaches the period logic three cycles later: two synchronizer stages and one edge register. The averaged sum updates on the next edge, and `early_steer` with `digit_code` registers one cycle after that. So a result is due about five cycles after the fifth rising edge of the later channel. A fall after silence is due at about CLK_HZ/250 + 6 cycles. The scoreboard pops an expected code only when it sees `early_steer` rise, so this latency never needs to be exact. The level checks wait until a tone burst has ended, or until 600 idle cycles have passed against a 400-cycle timeout, before they sample.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;

  typedef logic [1:0] tone_idx_t;

  // Nominal frequency in Hz of entry idx of the low (hi_grp=0) or high group
  function automatic int unsigned grp_freq(input bit hi_grp, input int idx);
    int unsigned f;
    case ({hi_grp, 2'(idx)})
      3'b000:  f = 697;
      3'b001:  f = 770;
      3'b010:  f = 852;
      3'b011:  f = 941;
      3'b100:  f = 1209;
      3'b101:  f = 1336;
      3'b110:  f = 1477;
      default: f = 1633;
    endcase
    return f;
  endfunction

  // Row/column index pair to the 4-bit digit code
  function automatic logic [3:0] pair_code(input tone_idx_t row, input tone_idx_t col);
    logic [3:0] c;
    if (col == 2'd3)
      c = (row == 2'd3) ? 4'd0 : 4'd13 + {2'b00, row};
    else if (row == 2'd3)
      c = (col == 2'd0) ? 4'd11 : (col == 2'd1) ? 4'd10 : 4'd12;
    else
      c = 4'(int'(row) * 3 + int'(col) + 1);
    return c;
  endfunction

endpackage

// File: rtl/tone_window_match.sv
module tone_window_match
  import dtmf_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 3579545,
  parameter int unsigned AVG_N    = 4,
  parameter int unsigned TOL_DIV  = 40,
  parameter bit          HIGH_GRP = 1'b0,
  parameter int unsigned SW       = 17
) (
  input  logic [SW-1:0] period_sum,
  output logic          hit,
  output tone_idx_t     idx
);

  logic [31:0] sum_w;
  logic [3:0]  in_win;

  assign sum_w = 32'(period_sum);

  for (genvar g = 0; g < 4; g++) begin : g_win
    localparam int unsigned NOM  = AVG_N * CLK_HZ / grp_freq(HIGH_GRP, g);
    localparam int unsigned LO_B = NOM - NOM / TOL_DIV;
    localparam int unsigned HI_B = NOM + NOM / TOL_DIV;
    assign in_win[g] = (sum_w >= LO_B) && (sum_w <= HI_B);
  end

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int g = 0; g < 4; g++) begin
      if (in_win[g]) begin
        hit = 1'b1;
        idx = tone_idx_t'(g);
      end
    end
  end

endmodule

// File: rtl/tone_period_meter.sv
module tone_period_meter
  import dtmf_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 3579545,
  parameter int unsigned AVG_N       = 4,
  parameter int unsigned TOL_DIV     = 40,
  parameter int unsigned TIMEOUT_CYC = 14318,
  parameter bit          HIGH_GRP    = 1'b0
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wave_in,
  output logic      tone_ok,
  output tone_idx_t tone_idx
);

  localparam int unsigned CW = $clog2(TIMEOUT_CYC + 2);
  localparam int unsigned SW = CW + $clog2(AVG_N) + 1;
  localparam int unsigned FW = $clog2(AVG_N + 1);

  logic [2:0]    sync_q;
  logic          rise;
  logic [CW-1:0] cnt;
  logic          started;
  logic [FW-1:0] fill;
  logic [CW-1:0] hist [AVG_N];
  logic [SW-1:0] sum;
  logic          hit;

  assign rise = sync_q[1] & ~sync_q[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], wave_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      started <= 1'b0;
      fill    <= '0;
      sum     <= '0;
      for (int i = 0; i < AVG_N; i++) hist[i] <= '0;
    end else if (rise) begin
      cnt     <= CW'(1);
      started <= 1'b1;
      if (started) begin
        hist[0] <= cnt;
        for (int i = 1; i < AVG_N; i++) hist[i] <= hist[i-1];
        sum <= sum + SW'(cnt) - SW'(hist[AVG_N-1]);
        if (fill != FW'(AVG_N)) fill <= fill + 1'b1;
      end
    end else if (cnt > CW'(TIMEOUT_CYC)) begin
      started <= 1'b0;
      fill    <= '0;
      sum     <= '0;
      for (int i = 0; i < AVG_N; i++) hist[i] <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  tone_window_match #(
    .CLK_HZ  (CLK_HZ),
    .AVG_N   (AVG_N),
    .TOL_DIV (TOL_DIV),
    .HIGH_GRP(HIGH_GRP),
    .SW      (SW)
  ) u_match (
    .period_sum(sum),
    .hit       (hit),
    .idx       (tone_idx)
  );

  assign tone_ok = (fill == FW'(AVG_N)) && hit;

endmodule

// File: rtl/dtmf_pair_detector.sv
module dtmf_pair_detector
  import dtmf_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 3579545,
  parameter int unsigned AVG_N   = 4,
  parameter int unsigned TOL_DIV = 40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lo_wave,
  input  logic       hi_wave,
  output logic       early_steer,
  output logic [3:0] digit_code
);

  localparam int unsigned TIMEOUT_CYC = CLK_HZ / 250;

  logic [1:0] waves;
  logic [1:0] ch_ok;
  tone_idx_t  ch_idx [2];

  assign waves = {hi_wave, lo_wave};

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    tone_period_meter #(
      .CLK_HZ     (CLK_HZ),
      .AVG_N      (AVG_N),
      .TOL_DIV    (TOL_DIV),
      .TIMEOUT_CYC(TIMEOUT_CYC),
      .HIGH_GRP   (ch == 1)
    ) u_meter (
      .clk     (clk),
      .rst_n   (rst_n),
      .wave_in (waves[ch]),
      .tone_ok (ch_ok[ch]),
      .tone_idx(ch_idx[ch])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      early_steer <= 1'b0;
      digit_code  <= 4'd0;
    end else begin
      early_steer <= &ch_ok;
      if (&ch_ok) digit_code <= pair_code(ch_idx[0], ch_idx[1]);
    end
  end

endmodule

// File: rtl/dtmf_pair_checker.sv
module dtmf_pair_checker #(
  parameter int unsigned CLK_HZ = 3579545
) (
  input logic       clk,
  input logic       rst_n,
  input logic       lo_wave,
  input logic       hi_wave,
  input logic       early_steer,
  input logic [3:0] digit_code
);

  localparam int unsigned TIMEOUT_CYC = CLK_HZ / 250;
  localparam int unsigned GW = $clog2(TIMEOUT_CYC + 16);

  logic [1:0]    wv, wv_q;
  logic [GW-1:0] gap   [2];
  logic [2:0]    edges [2];

  assign wv = {hi_wave, lo_wave};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wv_q <= '0;
      for (int c = 0; c < 2; c++) begin
        gap[c]   <= '0;
        edges[c] <= '0;
      end
    end else begin
      wv_q <= wv;
      for (int c = 0; c < 2; c++) begin
        if (wv[c] && !wv_q[c]) begin
          gap[c] <= '0;
          if (edges[c] != 3'd7) edges[c] <= edges[c] + 1'b1;
        end else begin
          if (gap[c] != {GW{1'b1}}) gap[c] <= gap[c] + 1'b1;
          if (32'(gap[c]) > TIMEOUT_CYC) edges[c] <= '0;
        end
      end
    end
  end

  AST_RISE_AFTER_FIVE_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(early_steer) |-> (edges[0] >= 3'd5 && edges[1] >= 3'd5)); // R5

  AST_SILENT_LO_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(gap[0]) > TIMEOUT_CYC + 8) |-> !early_steer); // R7

  AST_SILENT_HI_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(gap[1]) > TIMEOUT_CYC + 8) |-> !early_steer); // R7

  AST_CODE_HELD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !early_steer |-> $stable(digit_code)); // R9

endmodule

bind dtmf_pair_detector dtmf_pair_checker #(.CLK_HZ(CLK_HZ)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lo_wave    (lo_wave),
  .hi_wave    (hi_wave),
  .early_steer(early_steer),
  .digit_code (digit_code)
);

// File: tb/test_dtmf_pair_detector.sv
`timescale 1ns/1ps
module test_dtmf_pair_detector;

  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       lo_wave = 1'b0;
  logic       hi_wave = 1'b0;
  logic       early_steer;
  logic [3:0] digit_code;

  int vectors = 0;
  int fails = 0;
  logic [3:0] exp_q[$];
  logic [3:0] last_code = 4'd0;
  logic       steer_prev = 1'b0;

  // half periods in cycles at CLK_HZ = 100000
  int lo_half[4] = '{72, 65, 59, 53};
  int hi_half[4] = '{41, 37, 34, 31};
  logic [3:0] code_tab[16] = '{4'd1, 4'd2, 4'd3, 4'd13, 4'd4, 4'd5, 4'd6, 4'd14,
                               4'd7, 4'd8, 4'd9, 4'd15, 4'd11, 4'd10, 4'd12, 4'd0};

  always #4 clk = ~clk;

  dtmf_pair_detector #(.CLK_HZ(100000)) i_dtmf_pair_detector (
    .clk(clk), .rst_n(rst_n), .lo_wave(lo_wave), .hi_wave(hi_wave),
    .early_steer(early_steer), .digit_code(digit_code)
  );

  task automatic chk(input bit ok, input string req, input logic [3:0] act, input logic [3:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: every rise of early_steer pops one expected code
  always @(negedge clk) begin
    if (rst_n) begin
      if (early_steer && !steer_prev) begin
        vectors++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R5/R6: actual rise with code %0d expected no rise", digit_code);
        end else begin
          logic [3:0] e;
          e = exp_q.pop_front();
          if (digit_code !== e) begin
            fails++;
            $display("FAIL R4: actual code %0d expected %0d", digit_code, e);
          end
        end
      end
      steer_prev = early_steer;
    end
  end

  task automatic drive_wave(input bit hi_ch, input int half, input int n,
                            input int g_idx, input int g_half);
    for (int p = 0; p < n; p++) begin
      int h;
      h = (p == g_idx) ? g_half : half;
      if (hi_ch) hi_wave = 1'b1; else lo_wave = 1'b1;
      repeat (h) @(negedge clk);
      if (hi_ch) hi_wave = 1'b0; else lo_wave = 1'b0;
      repeat (h) @(negedge clk);
    end
  endtask

  task automatic play(input int lh, input int ln, input int hh, input int hn,
                      input int g_idx, input int g_half);
    fork
      drive_wave(1'b0, lh, ln, -1, 0);
      drive_wave(1'b1, hh, hn, g_idx, g_half);
    join
  endtask

  task automatic idle_check(input string req);
    repeat (600) @(negedge clk);
    chk(early_steer == 1'b0, req, {3'b0, early_steer}, 4'd0);
    chk(digit_code == last_code, "R9", digit_code, last_code);
  endtask

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(early_steer == 1'b0, "R1", {3'b0, early_steer}, 4'd0);
    chk(digit_code == 4'd0, "R1", digit_code, 4'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(early_steer == 1'b0 && digit_code == 4'd0, "R1", digit_code, 4'd0);

    // R2 R3 R4: every row/column pair
    for (int r = 0; r < 4; r++) begin
      for (int c = 0; c < 4; c++) begin
        exp_q.push_back(code_tab[r*4+c]);
        last_code = code_tab[r*4+c];
        play(lo_half[r], 10, hi_half[c], 10, -1, 0);
        chk(exp_q.size() == 0, "R2/R3", 4'(exp_q.size()), 4'd0);
        idle_check("R7");
      end
    end

    // R5: four rising edges on the low channel are not enough
    play(lo_half[0], 4, hi_half[0], 10, -1, 0);
    chk(early_steer == 1'b0, "R5", {3'b0, early_steer}, 4'd0);
    idle_check("R5");
    // R5: the fifth rising edge completes the average
    exp_q.push_back(4'd1);
    last_code = 4'd1;
    play(lo_half[0], 5, hi_half[0], 10, -1, 0);
    chk(early_steer == 1'b1, "R5", {3'b0, early_steer}, 4'd1);
    idle_check("R5");

    // R6: 2% slow row 697 with 1477 is accepted
    exp_q.push_back(4'd3);
    last_code = 4'd3;
    play(73, 10, hi_half[2], 10, -1, 0);
    chk(exp_q.size() == 0, "R6", 4'(exp_q.size()), 4'd0);
    idle_check("R6");
    // R6: 7% slow row, between-group row, off column are all rejected
    play(77, 10, hi_half[0], 10, -1, 0);
    chk(early_steer == 1'b0, "R6", {3'b0, early_steer}, 4'd0);
    idle_check("R6");
    play(50, 10, hi_half[0], 10, -1, 0);
    chk(early_steer == 1'b0, "R6", {3'b0, early_steer}, 4'd0);
    idle_check("R6");
    play(lo_half[2], 10, 35, 10, -1, 0);
    chk(early_steer == 1'b0, "R6", {3'b0, early_steer}, 4'd0);
    idle_check("R6");

    // R7: column stops while row continues
    exp_q.push_back(4'd4);
    last_code = 4'd4;
    play(lo_half[1], 20, hi_half[0], 8, -1, 0);
    chk(early_steer == 1'b0, "R7", {3'b0, early_steer}, 4'd0);
    chk(exp_q.size() == 0, "R7", 4'(exp_q.size()), 4'd0);
    chk(digit_code == 4'd4, "R9", digit_code, 4'd4);
    idle_check("R7");

    // R8: one long column period drops and later restores steering
    exp_q.push_back(4'd5);
    exp_q.push_back(4'd5);
    last_code = 4'd5;
    play(lo_half[1], 36, hi_half[1], 50, 15, 60);
    chk(exp_q.size() == 0, "R8", 4'(exp_q.size()), 4'd0);
    idle_check("R8");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected end of test");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule